// File: doc/BRIEF.md
# Overflow-Policy Integer Adder

This block adds or subtracts two N-bit integers (32 by default) in a single combinational pass and applies one of three overflow policies picked by a mode input. In trap mode an exception line is raised when the chosen interpretation overflows. In wrap mode the modular result is returned silently. In saturate mode the result is clamped to the nearest representable extreme. Both a signed overflow flag and an unsigned carry/borrow flag are produced on every operation, whatever the policy.

Operands arrive on a valid/ready stream and the result leaves on another. The block holds no storage. The output valid follows the input valid, and the input ready follows the output ready, in the same cycle. A transfer therefore completes on both sides at once, and back-pressure from the consumer reaches the producer with no delay. When the input valid is low the exception line stays low, and the data outputs carry no meaning.

Top module: `ofa_adder`

## Requirements
- R1: In wrap mode (policy 2'b01) and in the reserved mode (2'b11), result equals A+B, or A-B when sub_sel=1, modulo 2^N. exc stays low in both modes.
- R2: ovf_signed is high exactly when the effective operands (A, and B inverted when subtracting) share a sign bit and the result's sign bit differs from A's. If their sign bits differ it is low.
- R3: ovf_unsigned is high for an add exactly when B > ~A as unsigned values. For a subtract it is high exactly when A < B as unsigned values (a borrow).
- R4: In trap mode (policy 2'b00), exc equals in_valid AND the selected flag. The selected flag is ovf_signed when signed_sel=1 and ovf_unsigned when signed_sel=0. result still carries the wrapped value.
- R5: In saturate mode (policy 2'b10), exc stays low.
- R6: In saturate mode with signed_sel=1, a signed overflow with A non-negative gives 0x7FFF_FFFF (the largest signed value), and one with A negative gives 0x8000_0000 (the smallest). With no overflow the wrapped value is given.
- R7: In saturate mode with signed_sel=0, an unsigned add overflow gives all ones, and an unsigned subtract borrow gives zero. With no overflow the wrapped value is given.
- R8: ovf_signed and ovf_unsigned do not depend on policy or signed_sel.
- R9: out_valid equals in_valid and in_ready equals out_ready combinationally. exc is low whenever in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block can accept the beat (mirrors out_ready) |
| a_op | input | N | First operand |
| b_op | input | N | Second operand |
| sub_sel | input | 1 | 1 = subtract B from A, 0 = add |
| signed_sel | input | 1 | 1 = signed interpretation selects trap/clamp, 0 = unsigned |
| policy | input | 2 | 00 trap, 01 wrap, 10 saturate, 11 treated as wrap |
| out_valid | output | 1 | Result beat present (mirrors in_valid) |
| out_ready | input | 1 | Consumer accepts the result |
| result | output | N | Wrapped or clamped result |
| ovf_signed | output | 1 | Two's complement overflow |
| ovf_unsigned | output | 1 | Carry out on add, borrow on subtract |
| exc | output | 1 | Trap-mode exception |

## Verification
The operands are drawn from every pair of 0, 1, the largest signed value, the smallest signed value and all ones. Each pair is run under both operations, both interpretations and all four policy codes. The pairs that mix the signed extremes tell positive from negative signed clamping. The pairs with all ones and zero tell an unsigned carry from a borrow. Pairs of opposite sign confirm that the signed flag stays low even when the carry is set. Random operands and beats with valid low or ready low then check that the flags ignore the policy, and that the handshake mirrors and exception gating hold away from the boundaries.

// File: rtl/ofa_pkg.sv
package ofa_pkg;
  typedef enum logic [1:0] {
    POL_TRAP = 2'b00,
    POL_WRAP = 2'b01,
    POL_SAT  = 2'b10,
    POL_RSVD = 2'b11
  } policy_e;
endpackage

// File: rtl/ofa_addcore.sv
// Single carry chain shared by add and subtract: A + (B ^ sub) + sub.
module ofa_addcore #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] b_eff,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum   = wide[W-1:0];
    cout  = wide[W];
  end
endmodule

// File: rtl/ofa_flags.sv
// Overflow detection for both interpretations from sign bits and carry out.
module ofa_flags #(
  parameter int W = 32
) (
  input  logic         a_msb,
  input  logic         beff_msb,
  input  logic         sum_msb,
  input  logic         cout,
  input  logic         sub,
  output logic         ovf_s,
  output logic         ovf_u
);
  logic same_sign;

  always_comb begin
    same_sign = ~(a_msb ^ beff_msb);
    ovf_s     = same_sign & (a_msb ^ sum_msb);
    ovf_u     = sub ? ~cout : cout;
  end
endmodule

// File: rtl/ofa_clamp.sv
// Policy stage: picks the wrapped sum or a clamp value and forms the exception.
module ofa_clamp
  import ofa_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] sum,
  input  logic         a_msb,
  input  logic         sub,
  input  logic         signed_sel,
  input  policy_e      pol,
  input  logic         ovf_s,
  input  logic         ovf_u,
  input  logic         valid,
  output logic [W-1:0] res,
  output logic         exc
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] UMAX = {W{1'b1}};
  localparam logic [W-1:0] UMIN = '0;

  logic sel_ovf;
  logic [W-1:0] clamp_v;

  always_comb begin
    sel_ovf = signed_sel ? ovf_s : ovf_u;
    if (signed_sel) clamp_v = a_msb ? SMIN : SMAX;
    else            clamp_v = sub ? UMIN : UMAX;
    res = ((pol == POL_SAT) && sel_ovf) ? clamp_v : sum;
    exc = valid && (pol == POL_TRAP) && sel_ovf;
  end
endmodule

// File: rtl/ofa_adder.sv
module ofa_adder
  import ofa_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] a_op,
  input  logic [N-1:0] b_op,
  input  logic         sub_sel,
  input  logic         signed_sel,
  input  logic [1:0]   policy,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] result,
  output logic         ovf_signed,
  output logic         ovf_unsigned,
  output logic         exc
);
  localparam int MSB = N - 1;

  logic [N-1:0] b_eff;
  logic [N-1:0] sum;
  logic         cout;
  policy_e      pol;

  assign pol       = policy_e'(policy);
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  ofa_addcore #(.W(N)) u_core (
    .a(a_op), .b(b_op), .sub(sub_sel),
    .b_eff(b_eff), .sum(sum), .cout(cout)
  );

  ofa_flags #(.W(N)) u_flags (
    .a_msb(a_op[MSB]), .beff_msb(b_eff[MSB]), .sum_msb(sum[MSB]),
    .cout(cout), .sub(sub_sel),
    .ovf_s(ovf_signed), .ovf_u(ovf_unsigned)
  );

  ofa_clamp #(.W(N)) u_clamp (
    .sum(sum), .a_msb(a_op[MSB]), .sub(sub_sel), .signed_sel(signed_sel),
    .pol(pol), .ovf_s(ovf_signed), .ovf_u(ovf_unsigned), .valid(in_valid),
    .res(result), .exc(exc)
  );
endmodule

// File: rtl/ofa_adder_chk.sv
module ofa_adder_chk #(
  parameter int N = 32
) (
  input logic         in_valid,
  input logic         in_ready,
  input logic [N-1:0] a_op,
  input logic [N-1:0] b_op,
  input logic         sub_sel,
  input logic         signed_sel,
  input logic [1:0]   policy,
  input logic         out_valid,
  input logic         out_ready,
  input logic [N-1:0] result,
  input logic         ovf_signed,
  input logic         ovf_unsigned,
  input logic         exc
);
  localparam logic [N-1:0] SMAX = {1'b0, {(N-1){1'b1}}};
  localparam logic [N-1:0] SMIN = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] bx;
  assign bx = sub_sel ? ~b_op : b_op;

  always_comb begin
    // R2: differing effective sign bits never overflow
    p_no_overflow_r2: assert ((a_op[N-1] != bx[N-1]) ? !ovf_signed : 1'b1);
    // R3: unsigned add flag is the comparison B > ~A; subtract flag is A < B
    p_ucarry_r3: assert (ovf_unsigned == (sub_sel ? (a_op < b_op) : (b_op > ~a_op)));
    // R4: trap exception gated by valid and the selected flag
    p_trap_r4: assert ((policy == 2'b00) ?
      (exc == (in_valid && (signed_sel ? ovf_signed : ovf_unsigned))) : 1'b1);
    // R5 and R1: no exception outside trap mode
    p_quiet_r5: assert ((policy != 2'b00) ? !exc : 1'b1);
    // R6: signed clamp lands on an extreme
    p_sclamp_r6: assert ((policy == 2'b10 && signed_sel && ovf_signed) ?
      (result == (a_op[N-1] ? SMIN : SMAX)) : 1'b1);
    // R9: handshake mirrors
    p_pass_r9: assert (out_valid == in_valid && in_ready == out_ready);
  end
endmodule

bind ofa_adder ofa_adder_chk #(.N(N)) i_chk (.*);

// File: tb/test_ofa_adder.sv
module test_ofa_adder;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         in_valid, in_ready, sub_sel, signed_sel, out_valid, out_ready;
  logic [W-1:0] a_op, b_op, result;
  logic [1:0]   policy;
  logic         ovf_signed, ovf_unsigned, exc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  ofa_adder #(.N(W)) i_ofa_adder (
    .in_valid(in_valid), .in_ready(in_ready), .a_op(a_op), .b_op(b_op),
    .sub_sel(sub_sel), .signed_sel(signed_sel), .policy(policy),
    .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .ovf_signed(ovf_signed), .ovf_unsigned(ovf_unsigned), .exc(exc)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h sub=%0b sgn=%0b pol=%0d act=%h exp=%h",
               tag, a_op, b_op, sub_sel, signed_sel, policy, act, exp);
    end
  endtask

  // Behavioural reference in wider precision
  task automatic compare();
    logic [W:0] ua, ub, ur;
    longint sa, sb, sr;
    bit e_ovs, e_ovu, e_sel, e_exc;
    logic [W-1:0] e_res, wrapped;
    ua = {1'b0, a_op};
    ub = {1'b0, b_op};
    ur = sub_sel ? ua - ub : ua + ub;
    wrapped = ur[W-1:0];
    sa = longint'($signed(a_op));
    sb = longint'($signed(b_op));
    sr = sub_sel ? sa - sb : sa + sb;
    e_ovs = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    e_ovu = sub_sel ? (a_op < b_op) : ur[W];
    e_sel = signed_sel ? e_ovs : e_ovu;
    e_res = wrapped;
    e_exc = 1'b0;
    case (policy)
      2'b00: e_exc = in_valid && e_sel;
      2'b10: if (e_sel) begin
        if (signed_sel) e_res = (sr > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
        else            e_res = sub_sel ? 32'h0 : 32'hFFFF_FFFF;
      end
      default: ;
    endcase
    if (policy == 2'b00 || policy == 2'b01 || policy == 2'b11)
      check("R1/R4 result", result, e_res);
    else if (signed_sel)
      check("R6 result", result, e_res);
    else
      check("R7 result", result, e_res);
    check("R2 ovf_signed", {31'b0, ovf_signed}, {31'b0, e_ovs});
    check("R3 ovf_unsigned", {31'b0, ovf_unsigned}, {31'b0, e_ovu});
    check((policy == 2'b00) ? "R4 exc" : "R5 exc", {31'b0, exc}, {31'b0, e_exc});
    check("R9 out_valid", {31'b0, out_valid}, {31'b0, in_valid});
    check("R9 in_ready", {31'b0, in_ready}, {31'b0, out_ready});
  endtask

  task automatic beat(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                      input logic sg, input logic [1:0] p, input logic v, input logic r);
    @(posedge clk);
    a_op = a; b_op = b; sub_sel = s; signed_sel = sg; policy = p;
    in_valid = v; out_ready = r;
    @(negedge clk);
    compare();
  endtask

  logic [W-1:0] pts [5];

  initial begin
    logic [W-1:0] ra, rb;
    logic rov_s, rov_u;
    pts[0] = 32'h0; pts[1] = 32'h1; pts[2] = 32'h7FFF_FFFF;
    pts[3] = 32'h8000_0000; pts[4] = 32'hFFFF_FFFF;
    in_valid = 0; out_ready = 0; a_op = 0; b_op = 0;
    sub_sel = 0; signed_sel = 0; policy = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset/idle state: no valid, no exception (R9)
    check("R9 idle out_valid", {31'b0, out_valid}, 32'h0);
    check("R9 idle exc", {31'b0, exc}, 32'h0);
    rst_n = 1'b1;
    // boundary sweep over all policies (R1..R7)
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int s = 0; s < 2; s++)
          for (int g = 0; g < 2; g++)
            for (int p = 0; p < 4; p++)
              beat(pts[i], pts[j], s[0], g[0], p[1:0], 1'b1, 1'b1);
    // valid low in trap mode: exception must stay low (R9, R4)
    beat(32'h7FFF_FFFF, 32'h1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1);
    beat(32'h0, 32'h1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
    // random: flags ignore policy and sign select (R8)
    for (int k = 0; k < 300; k++) begin
      ra = $urandom; rb = $urandom;
      beat(ra, rb, k[0], k[1], 2'b00, k[3], k[4]);
      rov_s = ovf_signed; rov_u = ovf_unsigned;
      for (int p = 1; p < 4; p++) begin
        beat(ra, rb, k[0], ~k[1], p[1:0], 1'b1, 1'b1);
        check("R8 ovf_signed stable", {31'b0, ovf_signed}, {31'b0, rov_s});
        check("R8 ovf_unsigned stable", {31'b0, ovf_unsigned}, {31'b0, rov_u});
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule